// File: doc/BRIEF.md
# Multi-Cycle Multiply-Divide Unit

This block is an arithmetic side unit for a 32-bit integer core. It holds a double-width accumulator split into a high word (HI) and a low word (LO). On an operation strobe it starts one of several jobs: a signed or unsigned full-width multiply, a multiply-accumulate that adds the product to HI:LO or subtracts it from HI:LO, a three-operand multiply that only replaces the low word, or a signed or unsigned divide that leaves the quotient in LO and the remainder in HI. Each job runs for a fixed number of cycles that depends on its kind, and a busy flag stays high for that whole time.

The core reads HI or LO through a read port whose valid flag stays low while a job is running, so a dependent read is held off until the result is committed. The core can also load HI or LO directly through a write port. Such a write cancels any job in progress. Signed accumulate jobs that leave the signed double-width range set a sticky overflow flag. When the job was issued with saturation requested, they also clamp the result to the nearest representable extreme.

Top module: `muldiv_unit`

## Requirements
- R1: After reset HI and LO are zero, busy is low, the overflow flag is low and a read returns valid data at once.
- R2: Opcodes 0 (signed) and 1 (unsigned) multiply the operands into the 2W-bit product and store it in HI:LO. Busy is high for exactly MUL_CYC cycles (4 by default) after the accepting edge.
- R3: Opcodes 2 (signed) and 3 (unsigned) add the product to HI:LO, and opcodes 4 (signed) and 5 (unsigned) subtract it from HI:LO, modulo 2^(2W). Busy is high for MUL_CYC+1 cycles.
- R4: Opcode 6 replaces LO with the low W bits of the signed product and leaves HI unchanged, after MUL_CYC busy cycles.
- R5: Opcode 7 (signed) and opcode 8 (unsigned) divide operand A by operand B. The quotient is truncated toward zero and goes to LO. The remainder takes the sign of the dividend and goes to HI. Unsigned divide keeps busy high for W+2 cycles and signed divide for W+3 cycles (34 and 35 at W=32).
- R6: A divide with B equal to zero takes its normal time and yields LO all ones and HI equal to operand A.
- R7: A signed accumulate (opcodes 2 and 4) whose exact result leaves the signed 2W-bit range sets the overflow flag, which stays set until reset. Unsigned accumulates never set it.
- R8: When an overflowing signed accumulate was issued with op_sat high, HI:LO becomes the most positive value if the accumulator was non-negative, and the most negative value otherwise. With op_sat low the result wraps.
- R9: rd_valid equals rd_req while busy is low and is low while busy is high. rd_data is HI when rd_sel is 1 and LO when rd_sel is 0.
- R10: wr_en loads wr_data into HI (wr_sel 1) or LO (wr_sel 0) at the next edge and leaves the other word unchanged. It cancels any running job, so busy is low from the next cycle. It takes precedence over a job completing in the same cycle and over a strobe in the same cycle.
- R11: A strobe given while busy is high, or with an opcode above 8, is ignored: busy, HI and LO are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_valid | input | 1 | Operation strobe |
| op_code | input | 4 | Operation select |
| op_a | input | W | Operand A / dividend |
| op_b | input | W | Operand B / divisor |
| op_sat | input | 1 | Request saturation for this accumulate |
| busy | output | 1 | A job is running |
| rd_req | input | 1 | Read request |
| rd_sel | input | 1 | Read select: 1 HI, 0 LO |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | W | Read data |
| wr_en | input | 1 | Direct write strobe |
| wr_sel | input | 1 | Write select: 1 HI, 0 LO |
| wr_data | input | W | Direct write data |
| ovf | output | 1 | Sticky signed accumulate overflow |

## Verification
A direct write of HI or LO can land in the same cycle as a job's final busy cycle, and it can also coincide with a new operation strobe. The bench provokes the first case by counting busy cycles from the accepting edge and raising wr_en so that it is sampled exactly at the completion edge. It expects the written word to hold the write data, the other word to keep its pre-job value and busy to be low. For the second case it issues a strobe together with a write. It expects busy to stay low and the accumulator to show only the write.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;

   typedef enum logic [3:0] {
      MD_MULS = 4'd0,
      MD_MULU = 4'd1,
      MD_MACS = 4'd2,
      MD_MACU = 4'd3,
      MD_MSBS = 4'd4,
      MD_MSBU = 4'd5,
      MD_MUL3 = 4'd6,
      MD_DIVS = 4'd7,
      MD_DIVU = 4'd8
   } md_op_e;

   function automatic logic md_legal(input logic [3:0] c);
      return c <= 4'd8;
   endfunction

   function automatic logic md_is_div(input logic [3:0] c);
      return (c == MD_DIVS) || (c == MD_DIVU);
   endfunction

   function automatic logic md_is_signed(input logic [3:0] c);
      return (c == MD_MULS) || (c == MD_MACS) || (c == MD_MSBS) ||
             (c == MD_MUL3) || (c == MD_DIVS);
   endfunction

endpackage

// File: rtl/muldiv_seq.sv
module muldiv_seq #(
   parameter int W       = 32,
   parameter int MUL_CYC = 4
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start,
   input  logic [3:0] op,
   input  logic       abort,
   output logic       busy,
   output logic       finish
);
   import muldiv_pkg::*;

   localparam int ACC_CYC  = MUL_CYC + 1;
   localparam int DIVU_CYC = W + 2;
   localparam int DIVS_CYC = W + 3;
   localparam int CW       = $clog2(DIVS_CYC + 1);

   logic [CW-1:0] cnt_q;
   logic          busy_q;

   function automatic int lat_of(input logic [3:0] c);
      case (c)
         MD_MULS, MD_MULU, MD_MUL3:          return MUL_CYC;
         MD_MACS, MD_MACU, MD_MSBS, MD_MSBU: return ACC_CYC;
         MD_DIVU:                            return DIVU_CYC;
         MD_DIVS:                            return DIVS_CYC;
         default:                            return 1;
      endcase
   endfunction

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         cnt_q  <= '0;
      end else if (abort) begin
         busy_q <= 1'b0;
         cnt_q  <= '0;
      end else if (start) begin
         busy_q <= 1'b1;
         cnt_q  <= CW'(lat_of(op) - 1);
      end else if (busy_q) begin
         if (cnt_q == '0) busy_q <= 1'b0;
         else             cnt_q  <= cnt_q - 1'b1;
      end
   end

   assign busy   = busy_q;
   assign finish = busy_q && (cnt_q == '0);

   // R2: an accepted job raises busy on the next cycle
   a_r2_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !abort) |=> busy_q);

   // R10: a cancel leaves the sequencer idle
   a_r10_abort_idle: assert property (@(posedge clk) disable iff (!rst_n)
      abort |=> !busy_q);

endmodule

// File: rtl/muldiv_mult.sv
module muldiv_mult #(
   parameter int W       = 32,
   parameter bit HAS_SAT = 1'b1
) (
   input  logic [3:0]     op,
   input  logic [W-1:0]   a,
   input  logic [W-1:0]   b,
   input  logic           sat,
   input  logic [2*W-1:0] acc,
   output logic [2*W-1:0] res,
   output logic           ovf_o
);
   import muldiv_pkg::*;

   localparam int DW = 2 * W;
   localparam logic [DW-1:0] POS_MAX = {1'b0, {(DW-1){1'b1}}};
   localparam logic [DW-1:0] NEG_MIN = {1'b1, {(DW-1){1'b0}}};

   logic           sgn;
   logic [DW-1:0]  ax, bx, prod;
   logic [DW-1:0]  sum, dif, raw, clamp, acc_res;
   logic           is_sub, ovf_add, ovf_sub, ovf_raw;

   assign sgn  = md_is_signed(op);
   assign ax   = {{W{sgn & a[W-1]}}, a};
   assign bx   = {{W{sgn & b[W-1]}}, b};
   assign prod = ax * bx;

   assign sum  = acc + prod;
   assign dif  = acc - prod;
   assign is_sub = (op == MD_MSBS) || (op == MD_MSBU);
   assign raw  = is_sub ? dif : sum;

   assign ovf_add = (acc[DW-1] == prod[DW-1]) && (sum[DW-1] != acc[DW-1]);
   assign ovf_sub = (acc[DW-1] != prod[DW-1]) && (dif[DW-1] != acc[DW-1]);
   assign ovf_raw = (op == MD_MACS) ? ovf_add :
                    (op == MD_MSBS) ? ovf_sub : 1'b0;

   assign clamp = acc[DW-1] ? NEG_MIN : POS_MAX;

   generate
      if (HAS_SAT) begin : g_sat
         assign acc_res = (ovf_raw && sat) ? clamp : raw;
      end else begin : g_wrap
         assign acc_res = raw;
      end
   endgenerate

   always_comb begin
      case (op)
         MD_MACS, MD_MACU, MD_MSBS, MD_MSBU: res = acc_res;
         MD_MUL3: res = {acc[DW-1:W], prod[W-1:0]};
         default: res = prod;
      endcase
   end

   assign ovf_o = ovf_raw;

endmodule

// File: rtl/muldiv_div.sv
module muldiv_div #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start,
   input  logic         sgn,
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   output logic [W-1:0] quo,
   output logic [W-1:0] rem
);
   localparam int SW = $clog2(W + 1);

   logic [W:0]    rem_q;
   logic [W-1:0]  quo_q, dvs_q, a_raw_q;
   logic [SW-1:0] steps_q;
   logic          neg_q_q, neg_r_q, zero_q;

   logic [W-1:0]  mag_a, mag_b;
   logic [W:0]    r_sh, r_sub, r_nxt;
   logic          r_ge;

   assign mag_a = (sgn && a[W-1]) ? (~a + 1'b1) : a;
   assign mag_b = (sgn && b[W-1]) ? (~b + 1'b1) : b;

   assign r_sh  = {rem_q[W-1:0], quo_q[W-1]};
   assign r_ge  = r_sh >= {1'b0, dvs_q};
   assign r_sub = r_sh - {1'b0, dvs_q};
   assign r_nxt = r_ge ? r_sub : r_sh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rem_q   <= '0;
         quo_q   <= '0;
         dvs_q   <= '0;
         a_raw_q <= '0;
         steps_q <= '0;
         neg_q_q <= 1'b0;
         neg_r_q <= 1'b0;
         zero_q  <= 1'b0;
      end else if (start) begin
         rem_q   <= '0;
         quo_q   <= mag_a;
         dvs_q   <= mag_b;
         a_raw_q <= a;
         steps_q <= SW'(W);
         neg_q_q <= sgn & (a[W-1] ^ b[W-1]);
         neg_r_q <= sgn & a[W-1];
         zero_q  <= (b == '0);
      end else if (steps_q != '0) begin
         rem_q   <= r_nxt;
         quo_q   <= {quo_q[W-2:0], r_ge};
         steps_q <= steps_q - 1'b1;
      end
   end

   assign quo = zero_q  ? {W{1'b1}} :
                neg_q_q ? (~quo_q + 1'b1) : quo_q;
   assign rem = zero_q  ? a_raw_q :
                neg_r_q ? (~rem_q[W-1:0] + 1'b1) : rem_q[W-1:0];

   // R5: a finished division leaves a magnitude remainder below the divisor
   a_r5_rem_bound: assert property (@(posedge clk) disable iff (!rst_n)
      (steps_q == '0 && dvs_q != '0) |-> (rem_q < {1'b0, dvs_q}));

endmodule

// File: rtl/muldiv_unit.sv
module muldiv_unit #(
   parameter int W       = 32,
   parameter int MUL_CYC = 4,
   parameter bit HAS_SAT = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         op_valid,
   input  logic [3:0]   op_code,
   input  logic [W-1:0] op_a,
   input  logic [W-1:0] op_b,
   input  logic         op_sat,
   output logic         busy,
   input  logic         rd_req,
   input  logic         rd_sel,
   output logic         rd_valid,
   output logic [W-1:0] rd_data,
   input  logic         wr_en,
   input  logic         wr_sel,
   input  logic [W-1:0] wr_data,
   output logic         ovf
);
   import muldiv_pkg::*;

   localparam int DW = 2 * W;

   generate
      if (W < 4) begin : g_bad_w
         $error("muldiv_unit: W must be at least 4");
      end
      if (MUL_CYC < 1) begin : g_bad_lat
         $error("muldiv_unit: MUL_CYC must be at least 1");
      end
   endgenerate

   logic [W-1:0]  hi_q, lo_q, a_q, b_q;
   logic [3:0]    op_q;
   logic          sat_q, ovf_q;
   logic          accept, finish, commit, busy_w;
   logic [DW-1:0] mres;
   logic          movf;
   logic [W-1:0]  dquo, drem;

   assign accept = op_valid && !busy_w && md_legal(op_code) && !wr_en;

   muldiv_seq #(.W(W), .MUL_CYC(MUL_CYC)) seq_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (accept),
      .op     (op_code),
      .abort  (wr_en),
      .busy   (busy_w),
      .finish (finish)
   );

   muldiv_mult #(.W(W), .HAS_SAT(HAS_SAT)) mult_i (
      .op    (op_q),
      .a     (a_q),
      .b     (b_q),
      .sat   (sat_q),
      .acc   ({hi_q, lo_q}),
      .res   (mres),
      .ovf_o (movf)
   );

   muldiv_div #(.W(W)) div_i (
      .clk   (clk),
      .rst_n (rst_n),
      .start (accept && md_is_div(op_code)),
      .sgn   (op_code == MD_DIVS),
      .a     (op_a),
      .b     (op_b),
      .quo   (dquo),
      .rem   (drem)
   );

   assign commit = finish && !wr_en;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         op_q  <= '0;
         a_q   <= '0;
         b_q   <= '0;
         sat_q <= 1'b0;
      end else if (accept) begin
         op_q  <= op_code;
         a_q   <= op_a;
         b_q   <= op_b;
         sat_q <= op_sat;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_q  <= '0;
         lo_q  <= '0;
         ovf_q <= 1'b0;
      end else if (wr_en) begin
         if (wr_sel) hi_q <= wr_data;
         else        lo_q <= wr_data;
      end else if (commit) begin
         if (md_is_div(op_q)) begin
            hi_q <= drem;
            lo_q <= dquo;
         end else begin
            hi_q <= mres[DW-1:W];
            lo_q <= mres[W-1:0];
            if (movf) ovf_q <= 1'b1;
         end
      end
   end

   assign busy     = busy_w;
   assign rd_valid = rd_req && !busy_w;
   assign rd_data  = rd_sel ? hi_q : lo_q;
   assign ovf      = ovf_q;

   // R7: overflow flag is sticky
   a_r7_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_q |=> ovf_q);

   // R11: an illegal strobe while idle starts nothing and changes nothing
   a_r11_illegal_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && !busy_w && !md_legal(op_code) && !wr_en)
      |=> (!busy_w && $stable(hi_q) && $stable(lo_q)));

   // R3: HI and LO hold while a job is still running
   a_r3_hold_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_w && !wr_en) |=> (!busy_w || ($stable(hi_q) && $stable(lo_q))));

   // R10: a direct write leaves the unselected word unchanged
   a_r10_write_other: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel) |=> $stable(lo_q));

endmodule

// File: tb/muldiv_unit_tb.sv
`timescale 1ns/1ps
module muldiv_unit_tb_top;

   localparam int W = 8;
   localparam int MUL_CYC = 4;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         op_valid = 1'b0;
   logic [3:0]   op_code = '0;
   logic [W-1:0] op_a = '0, op_b = '0;
   logic         op_sat = 1'b0;
   logic         busy;
   logic         rd_req = 1'b0, rd_sel = 1'b0;
   logic         rd_valid;
   logic [W-1:0] rd_data;
   logic         wr_en = 1'b0, wr_sel = 1'b0;
   logic [W-1:0] wr_data = '0;
   logic         ovf;

   int tests = 0;
   int fails = 0;
   bit done_flag = 1'b0;

   logic [7:0] m_hi = 8'h00, m_lo = 8'h00;
   bit         m_ovf = 1'b0;

   always #2 clk = ~clk;

   muldiv_unit #(.W(W), .MUL_CYC(MUL_CYC), .HAS_SAT(1'b1)) dut_i (
      .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
      .op_a(op_a), .op_b(op_b), .op_sat(op_sat), .busy(busy),
      .rd_req(rd_req), .rd_sel(rd_sel), .rd_valid(rd_valid), .rd_data(rd_data),
      .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .ovf(ovf)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic rd(input logic sel, output logic [7:0] d, output logic v);
      rd_req = 1'b1;
      rd_sel = sel;
      #1;
      d = rd_data;
      v = rd_valid;
      rd_req = 1'b0;
   endtask

   task automatic check_state(input string tag);
      logic [7:0] d;
      logic v;
      rd(1'b0, d, v);
      chk(v == 1'b1, {tag, " R9 lo valid"}, v, 1);
      chk(d == m_lo, {tag, " lo"}, d, m_lo);
      rd(1'b1, d, v);
      chk(v == 1'b1, {tag, " R9 hi valid"}, v, 1);
      chk(d == m_hi, {tag, " hi"}, d, m_hi);
      chk(ovf == m_ovf, {tag, " R7 ovf"}, ovf, m_ovf);
   endtask

   task automatic wr(input logic sel, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_sel = sel; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
      if (sel) m_hi = d; else m_lo = d;
   endtask

   function automatic int sx(input logic [7:0] x);
      return x[7] ? int'(x) - 256 : int'(x);
   endfunction

   // model update; returns expected latency
   function automatic int model(input logic [3:0] c, input logic [7:0] a,
                                input logic [7:0] b, input bit sat);
      int p, acc, s;
      logic [15:0] r;
      case (c)
         4'd0: begin p = sx(a) * sx(b); r = 16'(p); {m_hi, m_lo} = r; return MUL_CYC; end
         4'd1: begin p = int'(a) * int'(b); r = 16'(p); {m_hi, m_lo} = r; return MUL_CYC; end
         4'd6: begin p = sx(a) * sx(b); m_lo = 8'(p); return MUL_CYC; end
         4'd2, 4'd4: begin
            acc = sx(m_hi) * 256 + int'(m_lo);
            p = sx(a) * sx(b);
            s = (c == 4'd2) ? acc + p : acc - p;
            if (s > 32767 || s < -32768) begin
               m_ovf = 1'b1;
               if (sat) s = (acc >= 0) ? 32767 : -32768;
            end
            r = 16'(s); {m_hi, m_lo} = r;
            return MUL_CYC + 1;
         end
         4'd3, 4'd5: begin
            acc = int'({m_hi, m_lo});
            p = int'(a) * int'(b);
            s = (c == 4'd3) ? acc + p : acc - p;
            r = 16'(s); {m_hi, m_lo} = r;
            return MUL_CYC + 1;
         end
         4'd7: begin
            if (b == 8'h00) begin m_lo = 8'hFF; m_hi = a; end
            else begin m_lo = 8'(sx(a) / sx(b)); m_hi = 8'(sx(a) % sx(b)); end
            return W + 3;
         end
         4'd8: begin
            if (b == 8'h00) begin m_lo = 8'hFF; m_hi = a; end
            else begin m_lo = 8'(int'(a) / int'(b)); m_hi = 8'(int'(a) % int'(b)); end
            return W + 2;
         end
         default: return 0;
      endcase
   endfunction

   task automatic do_op(input logic [3:0] c, input logic [7:0] a,
                        input logic [7:0] b, input bit sat, input string tag);
      int exp_lat, cyc;
      exp_lat = model(c, a, b, sat);
      @(negedge clk);
      op_valid = 1'b1; op_code = c; op_a = a; op_b = b; op_sat = sat;
      @(negedge clk);
      op_valid = 1'b0;
      cyc = 0;
      while (busy && cyc < 100) begin
         cyc++;
         @(negedge clk);
      end
      chk(cyc == exp_lat, {tag, " latency"}, cyc, exp_lat);
      check_state(tag);
   endtask

   initial begin
      logic [7:0] d;
      logic v;
      int cyc;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(busy == 1'b0, "R1 busy", busy, 0);
      check_state("R1 reset");

      // R2 / R4 multiply sweeps
      for (int a = 0; a < 256; a += 5)
         for (int b = 0; b < 256; b += 23) begin
            do_op(4'd0, 8'(a), 8'(b), 1'b0, "R2 signed mul");
            do_op(4'd1, 8'(a), 8'(b), 1'b0, "R2 unsigned mul");
            do_op(4'd6, 8'(b), 8'(a), 1'b0, "R4 mul3");
         end
      do_op(4'd0, 8'h80, 8'h80, 1'b0, "R2 min*min");
      do_op(4'd1, 8'hFF, 8'hFF, 1'b0, "R2 max*max");

      // R3 / R7 / R8 accumulate sweeps
      for (int k = 0; k < 5; k++)
         for (int a = 0; a < 256; a += 37)
            for (int b = 0; b < 256; b += 41)
               for (int c = 2; c <= 5; c++)
                  for (int s = 0; s < 2; s++) begin
                     logic [15:0] seed;
                     case (k)
                        0: seed = 16'h0000;
                        1: seed = 16'h7FF0;
                        2: seed = 16'h8010;
                        3: seed = 16'hFFFF;
                        default: seed = 16'h1234;
                     endcase
                     wr(1'b1, seed[15:8]);
                     wr(1'b0, seed[7:0]);
                     do_op(4'(c), 8'(a), 8'(b), s[0], "R3 R7 R8 accumulate");
                  end

      // R5 / R6 divide sweeps
      for (int a = 0; a < 256; a += 5)
         for (int b = 0; b < 256; b += 7) begin
            do_op(4'd7, 8'(a), 8'(b), 1'b0, "R5 R6 signed div");
            do_op(4'd8, 8'(a), 8'(b), 1'b0, "R5 R6 unsigned div");
         end
      do_op(4'd7, 8'h80, 8'hFF, 1'b0, "R5 min/-1");
      do_op(4'd7, 8'h80, 8'h00, 1'b0, "R6 signed div0");
      do_op(4'd7, 8'hF9, 8'h02, 1'b0, "R5 neg dividend");
      do_op(4'd8, 8'hFF, 8'h01, 1'b0, "R5 div by one");

      // R11 strobe while busy ignored
      void'(model(4'd8, 8'd200, 8'd7, 1'b0));
      @(negedge clk);
      op_valid = 1'b1; op_code = 4'd8; op_a = 8'd200; op_b = 8'd7;
      @(negedge clk);
      op_code = 4'd0; op_a = 8'd3; op_b = 8'd3;
      cyc = 0;
      while (busy && cyc < 100) begin
         cyc++;
         @(negedge clk);
         op_valid = 1'b0;
      end
      chk(cyc == W + 2, "R11 busy strobe latency", cyc, W + 2);
      check_state("R11 busy strobe");

      // R11 illegal opcode ignored
      @(negedge clk);
      op_valid = 1'b1; op_code = 4'd12; op_a = 8'd9; op_b = 8'd9;
      @(negedge clk);
      op_valid = 1'b0;
      chk(busy == 1'b0, "R11 illegal busy", busy, 0);
      check_state("R11 illegal");

      // R10 abort mid-divide, with R9 read stall
      wr(1'b1, 8'h3C);
      @(negedge clk);
      op_valid = 1'b1; op_code = 4'd7; op_a = 8'h64; op_b = 8'h05;
      @(negedge clk);
      op_valid = 1'b0;
      rd(1'b0, d, v);
      chk(v == 1'b0, "R9 read stalled while busy", v, 0);
      @(negedge clk);
      wr_en = 1'b1; wr_sel = 1'b0; wr_data = 8'h5A;
      @(negedge clk);
      wr_en = 1'b0;
      m_lo = 8'h5A;
      chk(busy == 1'b0, "R10 abort busy", busy, 0);
      check_state("R10 abort");
      repeat (W + 4) @(negedge clk);
      check_state("R10 abort no late commit");

      // R10 write in the completion cycle wins
      wr(1'b1, 8'h11);
      wr(1'b0, 8'h22);
      @(negedge clk);
      op_valid = 1'b1; op_code = 4'd1; op_a = 8'd10; op_b = 8'd10;
      @(negedge clk);
      op_valid = 1'b0;
      repeat (MUL_CYC - 1) @(negedge clk);
      chk(busy == 1'b1, "R2 still busy before completion", busy, 1);
      wr_en = 1'b1; wr_sel = 1'b0; wr_data = 8'hA5;
      @(negedge clk);
      wr_en = 1'b0;
      m_lo = 8'hA5;
      chk(busy == 1'b0, "R10 completion collide busy", busy, 0);
      check_state("R10 completion collide");

      // R10 write and strobe in the same cycle
      @(negedge clk);
      op_valid = 1'b1; op_code = 4'd0; op_a = 8'd7; op_b = 8'd7;
      wr_en = 1'b1; wr_sel = 1'b1; wr_data = 8'h6B;
      @(negedge clk);
      op_valid = 1'b0; wr_en = 1'b0;
      m_hi = 8'h6B;
      chk(busy == 1'b0, "R10 write beats strobe busy", busy, 0);
      check_state("R10 write beats strobe");

      done_flag = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done_flag) begin
         tests++;
         fails++;
         $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

endmodule